// File: doc/BRIEF.md
# Five-Channel Down-Counter Timer Controller

The block holds five independent down-counting channels behind a small register window. Every channel has a count buffer, which is the value a count reloads from, and a live counter that software can read. Channels 0 to 3 also have a compare buffer. That buffer is stored and read back but does not affect counting here. One shared control word holds each channel's run, load, polarity and repeat bits. The block acts on the 0-to-1 and 1-to-0 transitions of these bits that a control write causes, not on their levels.

An external divider supplies a tick strobe for each channel. A running channel takes one count off per tick. When a tick arrives while the count is already zero, the channel signals expiry on its own `expire_o` bit for one cycle. It then either reloads and keeps running, or it stops and clears its own run bit in the control word. Channel 4 has a shortened field: run, load and repeat only.

Top module: `dtimer_ctrl`

## Requirements
- R1: After reset, every mapped register and every live count reads 0, `expire_o` is 0 and no channel runs.
- R2: Count buffer n is written and read at byte address 12+12n (n = 0..4). Compare buffer n is written and read at 16+12n (n = 0..3). Each holds 32 bits.
- R3: The control word is at address 0x08. Channel 0 owns bits 0..3 (run, load, polarity, repeat). Channel n in 1..3 owns bits 4n+4..4n+7 in the same order. Every other bit reads 0, so a write reads back as `wdata & 0x7FFF0F`.
- R4: A control write that takes a channel's load bit from 0 to 1 copies that channel's count buffer into its live counter, even while the channel runs. A write that leaves the load bit at 1 does not copy again.
- R5: A control write that takes a run bit from 0 to 1 starts the channel. One that takes it from 1 to 0 stops it, and the live count then holds its value under ticks.
- R6: While a channel runs, each tick on `tick_i[n]` decrements its live count by one. Ticks to a stopped channel change neither the count nor `expire_o`.
- R7: A tick that arrives while a running channel's count is 0 is an expiry. `expire_o[n]` is high for exactly the cycle after that tick.
- R8: On expiry with the repeat bit set, the live counter reloads from the count buffer and the run bit stays set.
- R9: On expiry with the repeat bit clear, the block clears that channel's run bit and the count stays at 0.
- R10: Channel 4 uses bit 20 for run, bit 21 for load and bit 22 for repeat. Bit 23 is not implemented.
- R11: A tick that coincides with a control write is not counted by any channel.
- R12: Live count n reads at 20+12n for n = 0..3 and at 0x40 for channel 4, and is read-only. Reads of unmapped addresses return 0. Writes to unmapped or read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_i | input | 5 | Per-channel count strobe |
| expire_o | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
A table of register writes runs first, each followed by a read-back. It covers buffers, a control word carrying unimplemented bits, unmapped addresses and a write to a read-only count. This separates the addresses that are storage, masked, or ignored.

Counting is then tried in four patterns, each on a different channel:
- a one-shot run to expiry, which separates counting past zero from stopping at zero;
- a repeating run, which shows the reload value and that the run bit survives;
- channel 4 with repeat set and then cleared, which shows its irregular bit positions;
- a tick that coincides with a control write, together with load-bit edges and held load levels, which separates edge action from level action.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int NUM_CH   = 5;
  localparam int LAST     = NUM_CH - 1;
  localparam int DW       = 32;
  localparam int CTL_ADDR = 8;

  function automatic int base_bit(int n);
    return (n == 0) ? 0 : 4 * n + 4;
  endfunction

  function automatic int start_bit(int n);
    return base_bit(n);
  endfunction

  function automatic int man_bit(int n);
    return base_bit(n) + 1;
  endfunction

  // last channel has no polarity bit, so its repeat bit shifts down
  function automatic int ar_bit(int n);
    return (n == LAST) ? base_bit(n) + 2 : base_bit(n) + 3;
  endfunction

  function automatic logic [DW-1:0] ctl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_CH; n++)
      for (int k = 0; k < ((n == LAST) ? 3 : 4); k++) m[base_bit(n) + k] = 1'b1;
    return m;
  endfunction

  function automatic int cnt_addr(int n);
    return 12 + 12 * n;
  endfunction

  function automatic int cmp_addr(int n);
    return 16 + 12 * n;
  endfunction

  function automatic int live_addr(int n);
    return (n == LAST) ? 16 + 12 * n : 20 + 12 * n;
  endfunction
endpackage

// File: rtl/dtimer_chan.sv
module dtimer_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;
  logic             step;
  logic             fire;

  assign step     = run_i & tick_i & ~hold_i;
  assign fire     = step & (cnt_q == '0);
  assign stop_o   = fire & ~reload_i;
  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire;
      if (load_i) cnt_q <= buf_i;
      else if (step) begin
        if (cnt_q == '0) begin
          if (reload_i) cnt_q <= buf_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load_i |=> $stable(cnt_q));

  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !hold_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q && $past(reload_i) |-> cnt_q == $past(buf_i));

  p_expire_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> $past(run_i) && $past(tick_i));
endmodule

// File: rtl/dtimer_rdmux.sv
module dtimer_rdmux
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 7
) (
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                ctrl_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_i,
  input  logic [LAST-1:0][CNT_W-1:0]   cmp_buf_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] live_i,
  output logic [DW-1:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CTL_ADDR)) rdata_o = ctrl_i;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr_i == AW'(cnt_addr(n)))  rdata_o = DW'(cnt_buf_i[n]);
      if (addr_i == AW'(live_addr(n))) rdata_o = DW'(live_i[n]);
    end
    for (int n = 0; n < LAST; n++)
      if (addr_i == AW'(cmp_addr(n))) rdata_o = DW'(cmp_buf_i[n]);
  end
endmodule

// File: rtl/dtimer_ctrl.sv
module dtimer_ctrl
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] expire_o
);
  localparam logic [DW-1:0] MASK = ctl_mask();

  logic [DW-1:0]                ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_q;
  logic [LAST-1:0][CNT_W-1:0]   cmp_buf_q;
  logic [NUM_CH-1:0][CNT_W-1:0] live;
  logic [NUM_CH-1:0]            load;
  logic [NUM_CH-1:0]            stop;
  logic                         ctl_wr;

  assign ctl_wr = wr_en_i && (addr_i == AW'(CTL_ADDR));

  // a control write wins over any expiry clearing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctl_wr) ctrl_q <= wdata_i & MASK;
    else begin
      for (int n = 0; n < NUM_CH; n++)
        if (stop[n]) ctrl_q[start_bit(n)] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int SB = start_bit(g);
    localparam int MB = man_bit(g);
    localparam int AB = ar_bit(g);

    assign load[g] = ctl_wr & wdata_i[MB] & ~ctrl_q[MB];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_buf_q[g] <= '0;
      else if (wr_en_i && addr_i == AW'(cnt_addr(g))) cnt_buf_q[g] <= wdata_i[CNT_W-1:0];
    end

    if (g < LAST) begin : g_cmp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_buf_q[g] <= '0;
        else if (wr_en_i && addr_i == AW'(cmp_addr(g))) cmp_buf_q[g] <= wdata_i[CNT_W-1:0];
      end
    end

    dtimer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (ctrl_q[SB]),
      .hold_i   (ctl_wr),
      .load_i   (load[g]),
      .reload_i (ctrl_q[AB]),
      .tick_i   (tick_i[g]),
      .buf_i    (cnt_buf_q[g]),
      .cnt_o    (live[g]),
      .expire_o (expire_o[g]),
      .stop_o   (stop[g])
    );

    p_start_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_wr && wdata_i[SB] |=> ctrl_q[SB]);

    p_stop_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[g] && !$past(ctrl_q[AB]) |-> !ctrl_q[SB]);

    p_repeat_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[g] && $past(ctrl_q[AB]) |-> ctrl_q[SB]);
  end

  p_ctl_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~MASK) == '0);

  dtimer_rdmux #(.CNT_W(CNT_W), .AW(AW)) u_rdmux (
    .addr_i    (addr_i),
    .ctrl_i    (ctrl_q),
    .cnt_buf_i (cnt_buf_q),
    .cmp_buf_i (cmp_buf_q),
    .live_i    (live),
    .rdata_o   (rdata_o)
  );
endmodule

// File: tb/tb_dtimer_ctrl.sv
module tb_dtimer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tick = '0;
  logic [4:0]  expire;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  dtimer_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .expire_o(expire)
  );

  // address, write data, expected read-back (R2, R3, R12)
  localparam int NV = 10;
  localparam logic [6:0]  V_ADDR [NV] = '{7'h0C, 7'h10, 7'h24, 7'h34, 7'h3C,
                                          7'h08, 7'h00, 7'h44, 7'h14, 7'h08};
  localparam logic [31:0] V_DATA [NV] = '{32'h11111111, 32'h22222222, 32'h33333333,
                                          32'h44444444, 32'h55555555, 32'h008004F4,
                                          32'hFFFFFFFF, 32'h0000ABCD, 32'h00001234, 32'h0};
  localparam logic [31:0] V_EXP  [NV] = '{32'h11111111, 32'h22222222, 32'h33333333,
                                          32'h44444444, 32'h55555555, 32'h00000404,
                                          32'h0, 32'h0, 32'h0, 32'h0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [4:0] tk);
    wr_en = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0; tick = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic tk(input logic [4:0] m, input logic [4:0] exp_expire, input string req);
    tick = m;
    @(negedge clk);
    tick = '0;
    check(req, {27'b0, expire}, {27'b0, exp_expire});
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string req);
    logic [31:0] r;
    rd(a, r);
    check(req, r, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 'h48; a += 4) rd_chk(7'(a), 32'h0, "R1 reset read");
    check("R1 expire", {27'b0, expire}, 32'h0);

    // table walk: R2 R3 R12
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i], 5'b0);
      rd(V_ADDR[i], v);
      check($sformatf("R2/R3/R12 table %0d", i), v, V_EXP[i]);
    end

    // channel 0 one-shot: R4 R5 R6 R7 R9
    wr(7'h0C, 32'd3, 5'b0);
    wr(7'h08, 32'h2, 5'b0);
    rd_chk(7'h14, 32'd3, "R4 load ch0");
    wr(7'h08, 32'h1, 5'b0);
    tk(5'h01, 5'h00, "R6 tick1");
    rd_chk(7'h14, 32'd2, "R6 dec ch0");
    tk(5'h01, 5'h00, "R6 tick2");
    tk(5'h01, 5'h00, "R6 tick3");
    rd_chk(7'h14, 32'd0, "R6 ch0 zero");
    tk(5'h01, 5'h01, "R7 expire ch0");
    rd_chk(7'h08, 32'h0, "R9 run bit cleared");
    rd_chk(7'h14, 32'd0, "R9 count stays 0");
    tk(5'h01, 5'h00, "R6 stopped tick no expire");
    rd_chk(7'h14, 32'd0, "R6 stopped count");

    // channel 1 repeat: R3 R8 R5
    wr(7'h18, 32'd1, 5'b0);
    wr(7'h08, 32'h200, 5'b0);
    rd_chk(7'h20, 32'd1, "R4 load ch1");
    wr(7'h08, 32'h900, 5'b0);
    tk(5'h02, 5'h00, "R6 ch1 tick");
    rd_chk(7'h20, 32'd0, "R6 ch1 zero");
    tk(5'h02, 5'h02, "R7 expire ch1");
    rd_chk(7'h20, 32'd1, "R8 reload ch1");
    rd_chk(7'h08, 32'h900, "R8 run kept");
    tk(5'h02, 5'h00, "R8 ch1 keeps running");
    tk(5'h02, 5'h02, "R8 second expiry");
    wr(7'h08, 32'h800, 5'b0);
    tk(5'h02, 5'h00, "R5 stopped no expire");
    rd_chk(7'h20, 32'd1, "R5 count frozen");

    // channel 4: R10 R3 R8 R9
    wr(7'h3C, 32'd2, 5'b0);
    wr(7'h08, 32'h200000, 5'b0);
    rd_chk(7'h40, 32'd2, "R10 load ch4");
    wr(7'h08, 32'hD00000, 5'b0);
    rd_chk(7'h08, 32'h500000, "R10 bit23 absent");
    tk(5'h10, 5'h00, "R10 tick");
    tk(5'h10, 5'h00, "R10 tick");
    tk(5'h10, 5'h10, "R10 expire ch4");
    rd_chk(7'h40, 32'd2, "R10 reload ch4");
    rd_chk(7'h08, 32'h500000, "R10 run kept");
    wr(7'h08, 32'h100000, 5'b0);
    tk(5'h10, 5'h00, "R10 tick");
    tk(5'h10, 5'h00, "R10 tick");
    tk(5'h10, 5'h10, "R10 expire one-shot");
    rd_chk(7'h08, 32'h0, "R10 bit20 cleared");

    // channel 2: R11 and R4 edge vs level
    wr(7'h24, 32'd5, 5'b0);
    wr(7'h08, 32'h2000, 5'b0);
    wr(7'h08, 32'h1000, 5'b0);
    wr(7'h08, 32'h1000, 5'h04);
    check("R11 expire", {27'b0, expire}, 32'h0);
    rd_chk(7'h2C, 32'd5, "R11 tick during write ignored");
    tk(5'h04, 5'h00, "R6 ch2 tick");
    rd_chk(7'h2C, 32'd4, "R6 ch2 dec");
    wr(7'h24, 32'd9, 5'b0);
    wr(7'h08, 32'h3000, 5'b0);
    rd_chk(7'h2C, 32'd9, "R4 load while running");
    tk(5'h04, 5'h00, "R6 ch2 tick");
    wr(7'h08, 32'h3000, 5'b0);
    rd_chk(7'h2C, 32'd8, "R4 held level no reload");
    wr(7'h08, 32'h0, 5'b0);

    // channel 3 never started: R6
    tk(5'h08, 5'h00, "R6 ch3 stopped");
    rd_chk(7'h38, 32'd0, "R6 ch3 count");
    rd_chk(7'h34, 32'h44444444, "R2 cmp3 kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule